// File: doc/BRIEF.md
# Successive-Approximation ADC Sequencer

This block is the digital controller that sits next to an on-chip analog-to-digital converter. Software reaches it through a small byte-wide register port. The registers select the conversion clock, hold the channel and port configuration, carry a software start bit and a busy status bit, return a 10-bit result split over two bytes, and hold an interrupt request flag with its enable.

The system clock is divided by 2, 8 or 32 to make the conversion clock. A start pulse has three writes: the start bit goes low, then high, then low. While the bit is high the converter is held in reset. When the bit goes low again, one conversion-clock cycle of sampling begins, followed by ten bit trials from the most significant bit down. During each trial the block drives a DAC code and reads one comparator bit. When the last trial ends, the busy bit clears, the result registers load, and the interrupt request flag is set.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, every readable register returns 0x00, the busy bit is 0 and `irq_o` is 0.
- R2: The clock-select register is at address 1. Its bits [1:0] and bit 7 read back as written, and bits [6:2] always read 0. The control register is at address 0 and reads as {start bit 7, busy bit 6, configuration bits [5:0]}.
- R3: The conversion clock period N is 2, 8, 32 or 32 system clocks for clock codes 00, 01, 10 and 11. Code 11 uses divide-by-32 and does not stall. Count from the clock edge that writes the start bit from 1 to 0. The busy bit clears exactly 11·N system clocks later.
- R4: The busy bit reads 1 from the edge that writes the start bit from 0 to 1 until the conversion completes.
- R5: The result equals the binary search driven by `cmp_in`, where 1 means the input is at or above `dac_code`. The value is left-justified: address 2 holds result bits [9:2], and address 3 holds result bits [1:0] in its bits [7:6], with 0 in bits [5:0].
- R6: The interrupt request flag (address 4, bit 0) is set on the same edge where busy clears after a completed conversion. It stays set until a write to address 4 with bit 0 = 0. Writing bit 0 = 1 does not set it. If completion and a clearing write fall on the same edge, the flag ends up set.
- R7: `irq_o` is high exactly when the flag is set and the enable bit (address 4, bit 1) is 1.
- R8: Raising the start bit during a conversion aborts it. The next falling edge restarts with the full 11·N timing. The result registers keep their old value until the new conversion completes.
- R9: Writing different configuration bits [5:0] to address 0 during sampling or bit trials stops the conversion. Busy then stays 1, no result loads and the flag is not set, until a new start pulse is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Read data, combinational from rd_addr |
| cmp_in | input | 1 | Comparator output, 1 when the input is at or above dac_code |
| dac_code | output | 10 | Trial code sent to the DAC |
| irq_o | output | 1 | Interrupt request, flag gated by enable |

## Verification
Two events can land on the same edge: completion sets the interrupt flag, and software writes 0 to clear it. The bench counts the exact 11·N cycle completion point and times a clearing write so that it takes effect on that edge. It then expects the flag to read 1, and a second write clears it. A second overlap is a configuration change during a conversion. There the bench checks that the busy bit stays 1 long after the normal completion time, that the result is unchanged and that the flag stays clear.

// File: rtl/adc_pkg.sv
package adc_pkg;
  localparam int ADC_BITS = 10;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HOLD,
    ST_SAMPLE,
    ST_CONV,
    ST_HALT
  } adc_state_e;

  // Conversion clock period in system clocks; code 3 falls back to the slowest ratio.
  function automatic logic [5:0] div_ratio(input logic [1:0] code);
    case (code)
      2'b00:   div_ratio = 6'd2;
      2'b01:   div_ratio = 6'd8;
      default: div_ratio = 6'd32;
    endcase
  endfunction

  function automatic logic [7:0] res_high(input logic [ADC_BITS-1:0] r);
    res_high = r[ADC_BITS-1 -: 8];
  endfunction

  function automatic logic [7:0] res_low(input logic [ADC_BITS-1:0] r);
    res_low = {r[ADC_BITS-9:0], {(16-ADC_BITS){1'b0}}};
  endfunction
endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div #(
  parameter int CNT_W = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic [1:0] sel,
  output logic       tick
);
  import adc_pkg::*;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;

  always_comb begin
    last = CNT_W'(div_ratio(sel) - 6'd1);
    tick = (cnt_q == last);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (clear)       cnt_q <= '0;
    else if (cnt_q >= last) cnt_q <= '0;
    else                  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/adc_sar_engine.sv
module adc_sar_engine #(
  parameter int BITS = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_rise,
  input  logic            start_fall,
  input  logic            cfg_change,
  input  logic            tick,
  input  logic            cmp_in,
  output logic            busy,
  output logic            done_pulse,
  output logic [BITS-1:0] dac_code,
  output logic [BITS-1:0] result
);
  import adc_pkg::*;

  localparam int IDX_W = $clog2(BITS);

  adc_state_e      state_q;
  logic [BITS-1:0] sar_q;
  logic [IDX_W-1:0] idx_q;
  logic [BITS-1:0] cur_bit;
  logic [BITS-1:0] next_bit;
  logic [BITS-1:0] sar_kept;
  logic            last_trial;

  always_comb begin
    cur_bit    = {{(BITS-1){1'b0}}, 1'b1} << idx_q;
    next_bit   = (idx_q == '0) ? '0 : ({{(BITS-1){1'b0}}, 1'b1} << (idx_q - 1'b1));
    sar_kept   = cmp_in ? sar_q : (sar_q & ~cur_bit);
    last_trial = (idx_q == '0);
    busy       = (state_q != ST_IDLE);
    dac_code   = sar_q;
    done_pulse = (state_q == ST_CONV) && tick && last_trial && !cfg_change && !start_rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sar_q   <= '0;
      idx_q   <= '0;
      result  <= '0;
    end else if (start_rise) begin
      state_q <= ST_HOLD;
      sar_q   <= '0;
    end else begin
      case (state_q)
        ST_HOLD: if (start_fall) begin
          state_q <= ST_SAMPLE;
          sar_q   <= '0;
        end
        ST_SAMPLE: begin
          if (cfg_change) state_q <= ST_HALT;
          else if (tick) begin
            state_q <= ST_CONV;
            sar_q   <= {1'b1, {(BITS-1){1'b0}}};
            idx_q   <= IDX_W'(BITS-1);
          end
        end
        ST_CONV: begin
          if (cfg_change) state_q <= ST_HALT;
          else if (tick) begin
            if (last_trial) begin
              result  <= sar_kept;
              sar_q   <= sar_kept;
              state_q <= ST_IDLE;
            end else begin
              sar_q <= sar_kept | next_bit;
              idx_q <= idx_q - 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int ADDR_W = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [7:0]                  wr_data,
  input  logic [ADDR_W-1:0]           rd_addr,
  output logic [7:0]                  rd_data,
  input  logic                        cmp_in,
  output logic [adc_pkg::ADC_BITS-1:0] dac_code,
  output logic                        irq_o
);
  import adc_pkg::*;

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CSEL = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_RHI  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_RLO  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_IRQ  = ADDR_W'(4);

  logic [5:0] cfg_q;
  logic       start_q;
  logic [1:0] csel_q;
  logic       test_q;
  logic       irq_flag_q;
  logic       irq_en_q;

  // Named internal events, also observed by the bound checker.
  logic ctrl_wr, irq_wr, start_rise, start_fall, cfg_change, flag_clr;
  logic conv_tick, conv_done, busy;
  logic [ADC_BITS-1:0] result;

  always_comb begin
    ctrl_wr    = wr_en && (wr_addr == A_CTRL);
    irq_wr     = wr_en && (wr_addr == A_IRQ);
    start_rise = ctrl_wr && wr_data[7] && !start_q;
    start_fall = ctrl_wr && !wr_data[7] && start_q;
    cfg_change = ctrl_wr && (wr_data[5:0] != cfg_q);
    flag_clr   = irq_wr && !wr_data[0];
  end

  adc_clk_div #(.CNT_W(6)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (start_fall),
    .sel   (csel_q),
    .tick  (conv_tick)
  );

  adc_sar_engine #(.BITS(ADC_BITS)) u_sar (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_rise (start_rise),
    .start_fall (start_fall),
    .cfg_change (cfg_change),
    .tick       (conv_tick),
    .cmp_in     (cmp_in),
    .busy       (busy),
    .done_pulse (conv_done),
    .dac_code   (dac_code),
    .result     (result)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q      <= '0;
      start_q    <= 1'b0;
      csel_q     <= '0;
      test_q     <= 1'b0;
      irq_flag_q <= 1'b0;
      irq_en_q   <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        cfg_q   <= wr_data[5:0];
        start_q <= wr_data[7];
      end
      if (wr_en && wr_addr == A_CSEL) begin
        csel_q <= wr_data[1:0];
        test_q <= wr_data[7];
      end
      if (irq_wr) irq_en_q <= wr_data[1];
      if (conv_done)     irq_flag_q <= 1'b1;
      else if (flag_clr) irq_flag_q <= 1'b0;
    end
  end

  assign irq_o = irq_flag_q && irq_en_q;

  always_comb begin
    case (rd_addr)
      A_CTRL:  rd_data = {start_q, busy, cfg_q};
      A_CSEL:  rd_data = {test_q, 5'b0, csel_q};
      A_RHI:   rd_data = res_high(result);
      A_RLO:   rd_data = res_low(result);
      A_IRQ:   rd_data = {6'b0, irq_en_q, irq_flag_q};
      default: rd_data = 8'h00;
    endcase
  end
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       conv_tick,
  input logic       conv_done,
  input logic       start_rise,
  input logic       cfg_change,
  input logic       busy,
  input logic       irq_flag_q,
  input logic       irq_en_q,
  input logic       irq_wr,
  input logic       flag_clr,
  input logic       irq_o,
  input logic [9:0] result
);
  assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    conv_tick |=> !conv_tick);

  assert_rise_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start_rise |=> busy);

  assert_done_eoc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> (!busy && irq_flag_q));

  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag_q && !flag_clr) |=> irq_flag_q);

  assert_flag_no_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_flag_q && !conv_done) |=> !irq_flag_q);

  assert_irq_raise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && irq_en_q && !irq_wr) |=> irq_o);

  assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_done |=> $stable(result));

  assert_halt_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_change && busy && !start_rise) |=> busy);
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .conv_tick  (conv_tick),
  .conv_done  (conv_done),
  .start_rise (start_rise),
  .cfg_change (cfg_change),
  .busy       (busy),
  .irq_flag_q (irq_flag_q),
  .irq_en_q   (irq_en_q),
  .irq_wr     (irq_wr),
  .flag_clr   (flag_clr),
  .irq_o      (irq_o),
  .result     (result)
);

// File: tb/sim_adc_seq_ctrl.sv
`timescale 1ns/1ps
module sim_adc_seq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       cmp_in;
  logic [9:0] dac_code;
  logic       irq_o;
  logic [9:0] vin = '0;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  assign cmp_in = (vin >= dac_code);

  adc_seq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .cmp_in(cmp_in), .dac_code(dac_code), .irq_o(irq_o)
  );

  // {clock code, analog value}
  localparam logic [11:0] VEC [0:5] = '{
    {2'b00, 10'h000}, {2'b00, 10'h3FF}, {2'b01, 10'h2A5},
    {2'b10, 10'h15A}, {2'b11, 10'h201}, {2'b01, 10'h1FF}
  };

  function automatic int ratio_of(input logic [1:0] c);
    if (c == 2'b00) return 2;
    if (c == 2'b01) return 8;
    return 32;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    rd_addr = a; #0.1; d = rd_data;
  endtask

  // Issues start high then low; returns at the negedge right after the falling-edge write.
  task automatic pulse_start(input logic [5:0] cfg);
    wr(3'd0, {2'b10, cfg});
    wr(3'd0, {2'b00, cfg});
  endtask

  task automatic wait_idle(output int n);
    logic [7:0] d;
    n = 0;
    rd(3'd0, d);
    while (d[6] && n < 2000) begin
      @(negedge clk); n++; rd(3'd0, d);
    end
  endtask

  task automatic expect_result(input string req, input logic [9:0] v);
    logic [7:0] d;
    rd(3'd2, d); check(req, d, v[9:2]);
    rd(3'd3, d); check(req, d, {v[1:0], 6'b0});
  endtask

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), d); check("R1 reg", d, 0);
    end
    check("R1 irq_o", irq_o, 0);

    // R3 R5 R6: vector walk
    for (int i = 0; i < 6; i++) begin
      int nr;
      nr = ratio_of(VEC[i][11:10]);
      vin = VEC[i][9:0];
      wr(3'd1, {6'b0, VEC[i][11:10]});
      pulse_start(6'h05);
      wait_idle(n);
      check("R3 latency", n, 11 * nr);
      expect_result("R5 result", VEC[i][9:0]);
      rd(3'd4, d); check("R6 flag set", d[0], 1);
      wr(3'd4, 8'h00);
      rd(3'd4, d); check("R6 flag clear", d[0], 0);
    end

    // R2: register layout
    wr(3'd1, 8'hFF); rd(3'd1, d); check("R2 csel ff", d, 8'h83);
    wr(3'd1, 8'h7C); rd(3'd1, d); check("R2 csel 7c", d, 8'h00);
    wr(3'd0, 8'h2A); rd(3'd0, d); check("R2 ctrl", d, 8'h2A);

    // R4: busy while start held high
    wr(3'd0, 8'h80); rd(3'd0, d); check("R4 busy hold", d, 8'hC0);
    repeat (20) @(negedge clk);
    rd(3'd0, d); check("R4 busy hold late", d[6], 1);
    vin = 10'h123;
    wr(3'd0, 8'h00);
    wait_idle(n); check("R4 R3 latency", n, 22);
    expect_result("R5 after hold", 10'h123);

    // R6: writing 1 does not set the flag
    wr(3'd4, 8'h00); wr(3'd4, 8'h01);
    rd(3'd4, d); check("R6 write1 ignored", d[0], 0);

    // R7: gating
    vin = 10'h0F0; pulse_start(6'h00); wait_idle(n);
    check("R7 irq gated off", irq_o, 0);
    wr(3'd4, 8'h03); check("R7 irq on", irq_o, 1);
    wr(3'd4, 8'h02); check("R7 irq after clear", irq_o, 0);
    wr(3'd4, 8'h00);

    // R6: completion and clearing write on the same edge (N=2, done 22 edges after fall)
    vin = 10'h2C3; pulse_start(6'h00);
    repeat (21) @(negedge clk);
    wr(3'd4, 8'h00);
    rd(3'd4, d); check("R6 set wins", d[0], 1);
    rd(3'd0, d); check("R6 busy clear", d[6], 0);
    wr(3'd4, 8'h00); rd(3'd4, d); check("R6 cleared after", d[0], 0);

    // R8: abort and restart
    vin = 10'h3A1; pulse_start(6'h00);
    repeat (10) @(negedge clk);
    wr(3'd0, 8'h80);
    rd(3'd0, d); check("R8 busy on abort", d[6], 1);
    expect_result("R8 old result kept", 10'h2C3);
    wr(3'd0, 8'h00);
    wait_idle(n); check("R8 restart latency", n, 22);
    expect_result("R8 new result", 10'h3A1);
    wr(3'd4, 8'h00);

    // R9: configuration change halts
    vin = 10'h055; pulse_start(6'h00);
    repeat (5) @(negedge clk);
    wr(3'd0, 8'h03);
    repeat (100) @(negedge clk);
    rd(3'd0, d); check("R9 busy stays", d[6], 1);
    rd(3'd4, d); check("R9 no flag", d[0], 0);
    expect_result("R9 result kept", 10'h3A1);
    pulse_start(6'h03);
    wait_idle(n); check("R9 restart latency", n, 22);
    expect_result("R9 new result", 10'h055);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule